// File: doc/BRIEF.md
# Toggle-Monitored Watchdog Timer

This block supervises a processor through a single heartbeat line. The processor flips that line now and then. Every accepted transition, rising or falling, restarts an internal cycle counter. If the counter runs a full window of `TIMEOUT_CYCLES` clock cycles with no accepted transition, the active-low output `wdo_n` drops. It then stays low until the heartbeat line moves again. Reloading the counter by other means does not release it.

The heartbeat line passes through a two-flop synchronizer. Edges are found by comparing consecutive synchronized samples. Three conditions hold the counter at zero and make it ignore transitions:
- the line is flagged as undriven,
- the reset generator reports reset active,
- the supply is flagged as out of range.

A supply fault also forces `wdo_n` low at once. The output comes back in the same cycle the supply recovers, unless a timeout is latched. A timeout only drives `wdo_n`. It does not touch any reset. The default window equals 1.6 s at a 50 MHz clock.

Top module: `toggle_watchdog`

## Requirements
- R1: While `rst_n` is low, and right after it rises with `supply_ok` high, `wdo_n` is 1 and the window starts from zero.
- R2: After `TIMEOUT_CYCLES` consecutive enabled clock edges with no accepted transition, `wdo_n` goes to 0. With no hold active and no heartbeat transition, `wdo_n` is 0 after edge number `TIMEOUT_CYCLES` and still 1 after edge number `TIMEOUT_CYCLES`-1.
- R3: A 0-to-1 change of `wdi` is accepted on the third rising clock edge after the change. It restarts the window from zero.
- R4: A 1-to-0 change of `wdi` is accepted in the same way. A restart in the middle of a window postpones the timeout to a full `TIMEOUT_CYCLES` after the accepted edge.
- R5: Once `wdo_n` is 0 because of a timeout, it stays 0 for any number of cycles. It returns to 1 on the edge that accepts the next `wdi` transition.
- R6: While `wdi_undriven` is 1, the counter is held at zero and `wdi` transitions are ignored. A latched timeout stays latched, and no timeout occurs however long the flag is held.
- R7: While `sys_reset_active` is 1, the counter is held at zero and `wdi` transitions are ignored.
- R8: When every hold condition is released, the window starts from zero on the next clock edge. A `wdi` transition made during the hold is never accepted afterwards.
- R9: While `supply_ok` is 0, `wdo_n` is 0 with no clock edge needed, and the counter is held at zero. When `supply_ok` returns to 1, `wdo_n` returns to 1 without waiting for a clock edge, unless a timeout is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| wdi | input | 1 | Heartbeat line toggled by the processor (asynchronous) |
| wdi_undriven | input | 1 | 1 when the heartbeat line is floating or three-stated |
| supply_ok | input | 1 | 1 when the monitored supply is above its threshold |
| sys_reset_active | input | 1 | 1 while the reset generator holds the system in reset |
| wdo_n | output | 1 | Active-low watchdog timeout output |

## Verification
The hardest case to reach is a heartbeat transition made during a hold. The stale sample must not count as a kick once the hold lifts. To reach it, the bench first lets a timeout latch. It then raises the undriven flag, flips `wdi` under it, and lowers the flag. The bench checks two things: the output stays low through the release, and a fresh full window is needed afterwards. The window restart is shown in the same way for reset and supply holds. In each case the bench stops the count a few cycles short of expiry and measures the full window again after release.

// File: rtl/toggle_watchdog.sv
module toggle_watchdog #(
  parameter int TIMEOUT_CYCLES = 80_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi,
  input  logic wdi_undriven,
  input  logic supply_ok,
  input  logic sys_reset_active,
  output logic wdo_n
);

  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          expired_q;

  logic hold;
  logic kick;

  assign hold  = wdi_undriven | sys_reset_active | ~supply_ok;
  assign kick  = (sync_q[1] ^ prev_q) & ~hold;
  assign wdo_n = supply_ok & ~expired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], wdi};
      prev_q <= sync_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (hold) begin
      cnt_q     <= '0;
    end else if (kick) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (!expired_q) begin
      if (cnt_q == LAST) begin
        expired_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_expiry_after_full_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_q) |-> ($past(cnt_q) == LAST && !$past(hold)));

  assert_latch_cleared_only_by_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(expired_q) |-> ($past(sync_q[1]) != $past(prev_q)));

  assert_hold_freezes_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdi_undriven || sys_reset_active) |=> $stable(expired_q));

  assert_hold_clears_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_active |=> (cnt_q == '0));

  assert_output_release_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdo_n) |-> ($rose(supply_ok) || $fell(expired_q)));

endmodule

// File: tb/toggle_watchdog_test.sv
module toggle_watchdog_test;

  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdi = 1'b0;
  logic wdi_undriven = 1'b0;
  logic supply_ok = 1'b1;
  logic sys_reset_active = 1'b0;
  logic wdo_n;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  toggle_watchdog #(.TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rst_n(rst_n), .wdi(wdi), .wdi_undriven(wdi_undriven),
    .supply_ok(supply_ok), .sys_reset_active(sys_reset_active), .wdo_n(wdo_n)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (wdo_n !== exp) begin
      fails++;
      $display("FAIL %s: wdo_n=%b expected=%b at %0t", req, wdo_n, exp, $time);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic kick;
    @(negedge clk) wdi = ~wdi;
    adv(3);
  endtask

  task automatic test_reset_and_timeout;
    #1 check("R1 during reset", 1'b1);
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1 after reset", 1'b1);
    adv(TO - 1);
    check("R2 one short of window", 1'b1);
    adv(1);
    check("R2 window expired", 1'b0);
  endtask

  task automatic test_latch_and_rising;
    adv(30);
    check("R5 latched low", 1'b0);
    @(negedge clk) wdi = 1'b1;
    adv(2);
    check("R5 not yet accepted", 1'b0);
    adv(1);
    check("R5 released by transition", 1'b1);
    adv(TO - 1);
    check("R3 rising restart, before expiry", 1'b1);
    adv(1);
    check("R3 rising restart, expiry", 1'b0);
  endtask

  task automatic test_falling_midwindow;
    kick();
    adv(10);
    kick();
    adv(TO - 1);
    check("R4 falling restart postpones", 1'b1);
    adv(1);
    check("R4 falling restart expiry", 1'b0);
  endtask

  task automatic test_reset_hold;
    kick();
    adv(15);
    @(negedge clk) sys_reset_active = 1'b1;
    adv(10);
    check("R7 no timeout under reset hold", 1'b1);
    @(negedge clk) wdi = ~wdi;
    adv(5);
    @(negedge clk) sys_reset_active = 1'b0;
    #1;
    adv(TO - 1);
    check("R8 restart from zero after reset", 1'b1);
    adv(1);
    check("R8 expiry after reset release", 1'b0);
  endtask

  task automatic test_undriven;
    @(negedge clk) wdi_undriven = 1'b1;
    @(negedge clk) wdi = ~wdi;
    adv(6);
    check("R6 edge ignored while undriven", 1'b0);
    @(negedge clk) wdi_undriven = 1'b0;
    adv(5);
    check("R8 stale edge not accepted", 1'b0);
    kick();
    check("R6 live edge accepted", 1'b1);
    adv(12);
    @(negedge clk) wdi_undriven = 1'b1;
    adv(40);
    check("R6 halted while undriven", 1'b1);
    @(negedge clk) wdi_undriven = 1'b0;
    #1;
    adv(TO - 1);
    check("R6 restart from zero", 1'b1);
    adv(1);
    check("R6 expiry after release", 1'b0);
  endtask

  task automatic test_supply;
    kick();
    adv(5);
    @(negedge clk) supply_ok = 1'b0;
    #1 check("R9 forced low immediately", 1'b0);
    adv(30);
    check("R9 low during fault", 1'b0);
    @(negedge clk) supply_ok = 1'b1;
    #1 check("R9 immediate release", 1'b1);
    adv(TO - 1);
    check("R9 counter held during fault", 1'b1);
    adv(1);
    check("R9 expiry after recovery", 1'b0);
    @(negedge clk) supply_ok = 1'b0;
    adv(3);
    @(negedge clk) supply_ok = 1'b1;
    #1 check("R9 latched timeout survives recovery", 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    test_reset_and_timeout();
    test_latch_and_rising();
    test_falling_midwindow();
    test_reset_hold();
    test_undriven();
    test_supply();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule